// File: doc/BRIEF.md
# Priority-Ordered Transmit Mailbox Arbiter

This block keeps a bank of sixteen message mailboxes and decides which armed transmit mailbox is handed to the frame sender next. Each mailbox stores an operating mode, a 4-bit transmit priority, a 30-bit identifier word, eight data bytes, a data length code and a remote-request flag. Software programs a mailbox through a simple write port: it selects the mailbox with `wr_mb` and the register with `wr_sel`, then writes `wr_data`. Writing the control register with the request bit set arms the mailbox and clears its ready flag.

Whenever the sender is idle, the arbiter looks at all armed transmit mailboxes in one cycle. The numerically smallest priority wins, and on a tie the lowest mailbox index wins. The winner is offered on a valid/ready handshake and held unchanged until the sender accepts it. The sender then reports the outcome with a one-cycle `tx_done` or `tx_abort` pulse. That pulse frees the mailbox, updates its abort flag and latches an event bit. An event bit raises the mailbox interrupt only while the matching bit of `irq_en` is set.

The controller has three states: `ST_IDLE`, `ST_OFFER` and `ST_WAIT`. There are three transitions. *pick* goes from IDLE to OFFER when any candidate exists, and latches the winner. *accept* goes from OFFER to WAIT when `frm_ready` is high. *finish* goes from WAIT to IDLE on `tx_done` or `tx_abort`.

Top module: `txmb_arbiter`

## Requirements
- R1: After reset, every mailbox is ready (`mb_ready` = 16'hFFFF), with no abort, no interrupt and `frm_valid` low.
- R2: A control write (`wr_sel`=4) with bit 23 set, to a mailbox in transmit mode (mode code 3), clears that mailbox's ready bit. The same write takes DLC from bits 19:16 and RTR from bit 20. The mailbox is then offered with its identifier word and data, where `frm_data` = {data-high word, data-low word}.
- R3: Among armed mailboxes, the one with the smallest priority value (0 highest, 15 lowest) is offered first. The mode register (`wr_sel`=0) takes the mode from bits 26:24 and the priority from bits 19:16.
- R4: Armed mailboxes with equal priority are offered in increasing index order.
- R5: A transfer request to a mailbox whose mode is not transmit is ignored: its ready bit stays 1 and nothing is offered. Mode 0 means disabled.
- R6: An identifier write (`wr_sel`=1, bits 29:0, where bit 29 is the extended flag and a standard ID sits in bits 28:18) takes effect only while the mailbox mode is disabled. Otherwise it is ignored.
- R7: While `frm_valid` is high and `frm_ready` is low, `frm_valid` stays high and `frm_mb` does not change, even if a higher-priority mailbox is armed.
- R8: `tx_done` sets the in-flight mailbox's ready bit and clears its abort bit. `tx_abort` sets both its ready and abort bits. A new request clears the abort bit.
- R9: Each rise of a ready bit sets that mailbox's event bit. `irq[i]` is high exactly when event bit i and `irq_en[i]` are both set. A `ev_clr[i]` pulse clears event bit i.
- R10: `tx_done`/`tx_abort` pulses that arrive while no frame is in flight have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_mb | input | 4 | Mailbox index for the write |
| wr_sel | input | 3 | Register select: 0 mode, 1 identifier, 2 data low, 3 data high, 4 control |
| wr_data | input | 32 | Write data |
| irq_en | input | 16 | Per-mailbox interrupt enable |
| ev_clr | input | 16 | Per-mailbox event clear pulse |
| frm_valid | output | 1 | Frame offered to sender |
| frm_ready | input | 1 | Sender accepts the offered frame |
| frm_mb | output | 4 | Index of offered mailbox |
| frm_id | output | 30 | Identifier word of offered mailbox |
| frm_rtr | output | 1 | Remote-request flag |
| frm_dlc | output | 4 | Data length code |
| frm_data | output | 64 | Data bytes, high word first |
| tx_done | input | 1 | Sender reports successful transfer |
| tx_abort | input | 1 | Sender reports aborted transfer |
| mb_ready | output | 16 | Per-mailbox ready flags |
| mb_abort | output | 16 | Per-mailbox abort flags |
| irq | output | 16 | Per-mailbox interrupt lines |

## Verification
If the controller state or latched winner were wrong, the effect would show at the handshake within a cycle. The bench would see an offered mailbox in the wrong priority order, a `frm_mb` that changes before acceptance, or a frame that never appears and so empties the scoreboard late. A corrupted mailbox flag appears on `mb_ready`, `mb_abort` or `irq` on the edge after the request or the sender's pulse. Stray completion pulses sent while idle would show up there at once.

// File: rtl/txmb_pkg.sv
package txmb_pkg;
    localparam int ID_W     = 30;
    localparam int WORD_W   = 32;
    localparam int DLC_W    = 4;
    localparam int MODE_W   = 3;
    localparam int MODE_LSB = 24;
    localparam int PRIO_LSB = 16;
    localparam int DLC_LSB  = 16;
    localparam int REQ_BIT  = 23;
    localparam int RTR_BIT  = 20;

    localparam logic [MODE_W-1:0] MODE_OFF = 3'd0;
    localparam logic [MODE_W-1:0] MODE_TX  = 3'd3;

    typedef enum logic [2:0] {
        SEL_MODE = 3'd0,
        SEL_ID   = 3'd1,
        SEL_DLO  = 3'd2,
        SEL_DHI  = 3'd3,
        SEL_CTRL = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_WAIT  = 2'd2
    } arb_state_e;
endpackage

// File: rtl/txmb_store.sv
module txmb_store
    import txmb_pkg::*;
#(
    parameter int NUM_MB = 16,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = $clog2(NUM_MB)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_mb,
    input  logic [2:0]               wr_sel,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic [NUM_MB-1:0]        ev_clr,
    input  logic                     fin_done,
    input  logic                     fin_abort,
    input  logic [IDX_W-1:0]         fin_mb,
    input  logic [IDX_W-1:0]         rd_mb,
    output logic [NUM_MB-1:0]        cand,
    output logic [NUM_MB*PRIO_W-1:0] prio_flat,
    output logic [NUM_MB-1:0]        rdy,
    output logic [NUM_MB-1:0]        abt,
    output logic [NUM_MB-1:0]        evt,
    output logic [ID_W-1:0]          rd_id,
    output logic                     rd_rtr,
    output logic [DLC_W-1:0]         rd_dlc,
    output logic [2*WORD_W-1:0]      rd_data
);
    logic [MODE_W-1:0] mode_q [NUM_MB];
    logic [PRIO_W-1:0] prio_q [NUM_MB];
    logic [ID_W-1:0]   id_q   [NUM_MB];
    logic [WORD_W-1:0] dlo_q  [NUM_MB];
    logic [WORD_W-1:0] dhi_q  [NUM_MB];
    logic [DLC_W-1:0]  dlc_q  [NUM_MB];
    logic [NUM_MB-1:0] rtr_q, pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_MB; i++) begin
                mode_q[i] <= MODE_OFF;
                prio_q[i] <= '0;
                id_q[i]   <= '0;
                dlo_q[i]  <= '0;
                dhi_q[i]  <= '0;
                dlc_q[i]  <= '0;
            end
            rtr_q  <= '0;
            pend_q <= '0;
            rdy    <= '1;
            abt    <= '0;
            evt    <= '0;
        end else begin
            for (int i = 0; i < NUM_MB; i++) begin
                if (ev_clr[i]) evt[i] <= 1'b0;
                if (wr_en && wr_mb == IDX_W'(i)) begin
                    case (wr_sel)
                        SEL_MODE: begin
                            mode_q[i] <= wr_data[MODE_LSB +: MODE_W];
                            prio_q[i] <= wr_data[PRIO_LSB +: PRIO_W];
                        end
                        SEL_ID:  if (mode_q[i] == MODE_OFF) id_q[i] <= wr_data[ID_W-1:0];
                        SEL_DLO: dlo_q[i] <= wr_data;
                        SEL_DHI: dhi_q[i] <= wr_data;
                        SEL_CTRL: begin
                            if (wr_data[REQ_BIT] && mode_q[i] == MODE_TX && rdy[i]) begin
                                pend_q[i] <= 1'b1;
                                rdy[i]    <= 1'b0;
                                abt[i]    <= 1'b0;
                                rtr_q[i]  <= wr_data[RTR_BIT];
                                dlc_q[i]  <= wr_data[DLC_LSB +: DLC_W];
                            end
                        end
                        default: ;
                    endcase
                end
                if ((fin_done || fin_abort) && fin_mb == IDX_W'(i)) begin
                    pend_q[i] <= 1'b0;
                    rdy[i]    <= 1'b1;
                    abt[i]    <= fin_abort;
                    evt[i]    <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_MB; i++) begin
            cand[i] = pend_q[i] && (mode_q[i] == MODE_TX);
            prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
        end
    end

    assign rd_id   = id_q[rd_mb];
    assign rd_rtr  = rtr_q[rd_mb];
    assign rd_dlc  = dlc_q[rd_mb];
    assign rd_data = {dhi_q[rd_mb], dlo_q[rd_mb]};
endmodule

// File: rtl/txmb_pick.sv
module txmb_pick #(
    parameter int NUM_MB = 16,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = $clog2(NUM_MB)
) (
    input  logic [NUM_MB-1:0]        cand,
    input  logic [NUM_MB*PRIO_W-1:0] prio_flat,
    output logic                     any,
    output logic [IDX_W-1:0]         win_mb
);
    logic [PRIO_W-1:0] best;

    // Walk downward with <= so the lowest index keeps ties.
    always_comb begin
        best   = '1;
        win_mb = '0;
        any    = |cand;
        for (int i = NUM_MB - 1; i >= 0; i--) begin
            if (cand[i] && prio_flat[i*PRIO_W +: PRIO_W] <= best) begin
                best   = prio_flat[i*PRIO_W +: PRIO_W];
                win_mb = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/txmb_fsm.sv
module txmb_fsm
    import txmb_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any,
    input  logic [IDX_W-1:0] win_mb,
    input  logic             frm_ready,
    input  logic             tx_done,
    input  logic             tx_abort,
    output logic             frm_valid,
    output logic [IDX_W-1:0] cur_mb,
    output logic             fin_done,
    output logic             fin_abort
);
    arb_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cur_mb <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && any) cur_mb <= win_mb;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (any) nxt = ST_OFFER;
            ST_OFFER: if (frm_ready) nxt = ST_WAIT;
            ST_WAIT:  if (tx_done || tx_abort) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        frm_valid = (state == ST_OFFER);
        fin_done  = (state == ST_WAIT) && tx_done;
        fin_abort = (state == ST_WAIT) && !tx_done && tx_abort;
    end
endmodule

// File: rtl/txmb_arbiter.sv
module txmb_arbiter
    import txmb_pkg::*;
#(
    parameter int NUM_MB = 16,
    parameter int PRIO_W = 4,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_mb,
    input  logic [2:0]           wr_sel,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic [NUM_MB-1:0]    irq_en,
    input  logic [NUM_MB-1:0]    ev_clr,
    output logic                 frm_valid,
    input  logic                 frm_ready,
    output logic [IDX_W-1:0]     frm_mb,
    output logic [ID_W-1:0]      frm_id,
    output logic                 frm_rtr,
    output logic [DLC_W-1:0]     frm_dlc,
    output logic [2*WORD_W-1:0]  frm_data,
    input  logic                 tx_done,
    input  logic                 tx_abort,
    output logic [NUM_MB-1:0]    mb_ready,
    output logic [NUM_MB-1:0]    mb_abort,
    output logic [NUM_MB-1:0]    irq
);
    logic [NUM_MB-1:0]        cand, evt;
    logic [NUM_MB*PRIO_W-1:0] prio_flat;
    logic                     any, fin_done, fin_abort;
    logic [IDX_W-1:0]         win_mb, cur_mb;

    txmb_store #(.NUM_MB(NUM_MB), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mb(wr_mb), .wr_sel(wr_sel),
        .wr_data(wr_data), .ev_clr(ev_clr), .fin_done(fin_done), .fin_abort(fin_abort),
        .fin_mb(cur_mb), .rd_mb(cur_mb), .cand(cand), .prio_flat(prio_flat),
        .rdy(mb_ready), .abt(mb_abort), .evt(evt), .rd_id(frm_id), .rd_rtr(frm_rtr),
        .rd_dlc(frm_dlc), .rd_data(frm_data)
    );

    txmb_pick #(.NUM_MB(NUM_MB), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
        .cand(cand), .prio_flat(prio_flat), .any(any), .win_mb(win_mb)
    );

    txmb_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .any(any), .win_mb(win_mb), .frm_ready(frm_ready),
        .tx_done(tx_done), .tx_abort(tx_abort), .frm_valid(frm_valid), .cur_mb(cur_mb),
        .fin_done(fin_done), .fin_abort(fin_abort)
    );

    assign frm_mb = cur_mb;
    assign irq    = evt & irq_en;
endmodule

// File: rtl/txmb_chk.sv
module txmb_chk #(
    parameter int NUM_MB = 16,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frm_valid,
    input logic              frm_ready,
    input logic [IDX_W-1:0]  frm_mb,
    input logic [NUM_MB-1:0] mb_ready,
    input logic [NUM_MB-1:0] mb_abort,
    input logic [NUM_MB-1:0] irq,
    input logic [NUM_MB-1:0] irq_en,
    input logic              tx_done,
    input logic              tx_abort
);
    // R7
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && !frm_ready |=> frm_valid && $stable(frm_mb));

    // R2
    offer_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> !mb_ready[frm_mb]);

    // R8
    abort_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_abort & ~mb_ready) == '0);

    // R10
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mb_ready & ~$past(mb_ready)) != '0) |-> $past(tx_done || tx_abort));

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~$past(irq)) & ~((mb_ready & ~$past(mb_ready)) | (irq_en & ~$past(irq_en)))) == '0);
endmodule

bind txmb_arbiter txmb_chk #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_mb(frm_mb), .mb_ready(mb_ready), .mb_abort(mb_abort), .irq(irq),
    .irq_en(irq_en), .tx_done(tx_done), .tx_abort(tx_abort)
);

// File: tb/tb_txmb_arbiter.sv
module tb_txmb_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_mb = '0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] irq_en = '0, ev_clr = '0;
    logic        frm_valid, frm_ready = 1'b0, frm_rtr;
    logic [3:0]  frm_mb, frm_dlc;
    logic [29:0] frm_id;
    logic [63:0] frm_data;
    logic        tx_done = 1'b0, tx_abort = 1'b0;
    logic [15:0] mb_ready, mb_abort, irq;

    txmb_arbiter dut (.*);

    always #5 clk = ~clk;

    typedef struct { int mb; logic [29:0] id; logic [3:0] dlc; logic rtr; } exp_t;
    exp_t exp_q[$];
    int vectors = 0, misses = 0, accept_delay = 0, served = 0;
    bit abort_mode = 0, busy = 0, finished = 0;
    logic [29:0] id_tab [16];

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int mb, input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_mb = 4'(mb); wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    function automatic logic [63:0] data_of(input int mb);
        return {32'hD000_0000 | 32'(mb), 32'hA000_0000 | 32'(mb * 3)};
    endfunction

    task automatic cfg(input int mb, input int prio, input logic [29:0] id);
        wr(mb, 3'd0, 32'h0);
        wr(mb, 3'd1, {2'b0, id});
        id_tab[mb] = id;
        wr(mb, 3'd0, (32'd3 << 24) | (32'(prio) << 16));
        wr(mb, 3'd2, data_of(mb)[31:0]);
        wr(mb, 3'd3, data_of(mb)[63:32]);
    endtask

    task automatic arm(input int mb, input int dlc, input bit rtr);
        wr(mb, 3'd4, (32'd1 << 23) | (32'(rtr) << 20) | (32'(dlc) << 16));
    endtask

    task automatic expect_frame(input int mb, input int dlc, input bit rtr);
        exp_t e;
        e.mb = mb; e.id = id_tab[mb]; e.dlc = 4'(dlc); e.rtr = rtr;
        exp_q.push_back(e);
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Monitor acting as the frame sender
    initial begin
        forever begin
            @(negedge clk);
            if (frm_valid) begin
                exp_t e;
                busy = 1;
                if (exp_q.size() == 0) begin
                    check(0, "R5 unexpected frame", 64'(frm_mb), 64'hFF);
                    e.mb = frm_mb; e.id = frm_id; e.dlc = frm_dlc; e.rtr = frm_rtr;
                end else e = exp_q.pop_front();
                check(frm_mb == 4'(e.mb), "R3/R4 order mb", 64'(frm_mb), 64'(e.mb));
                check(frm_id == e.id, "R2/R6 frame id", 64'(frm_id), 64'(e.id));
                check(frm_dlc == e.dlc && frm_rtr == e.rtr, "R2 dlc/rtr",
                      {frm_rtr, frm_dlc}, {e.rtr, e.dlc});
                check(frm_data == data_of(e.mb), "R2 data", frm_data, data_of(e.mb));
                for (int k = 0; k < accept_delay; k++) begin
                    @(negedge clk);
                    check(frm_valid && frm_mb == 4'(e.mb), "R7 grant held", 64'(frm_mb), 64'(e.mb));
                end
                frm_ready = 1;
                @(negedge clk);
                frm_ready = 0;
                repeat (2) @(negedge clk);
                if (abort_mode) tx_abort = 1; else tx_done = 1;
                @(negedge clk);
                tx_done = 0; tx_abort = 0;
                served++;
                busy = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic [15:0] rsnap, isnap;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check(mb_ready == 16'hFFFF, "R1 ready", 64'(mb_ready), 64'hFFFF);
        check(mb_abort == 0 && irq == 0, "R1 abort/irq", {mb_abort, irq}, 0);
        check(frm_valid == 0, "R1 valid", 64'(frm_valid), 0);

        // R2: extended and standard frames, single mailbox each
        irq_en = 16'hFFFF;
        cfg(5, 3, 30'h3234_5678);
        cfg(10, 3, 30'(11'h123) << 18);
        expect_frame(5, 8, 0);
        arm(5, 8, 0);
        check(mb_ready[5] == 0, "R2 ready cleared", 64'(mb_ready[5]), 0);
        drain();
        check(mb_ready[5] == 1 && mb_abort[5] == 0, "R8 done", {mb_ready[5], mb_abort[5]}, 2'b10);
        check(irq[5] == 1, "R9 irq after done", 64'(irq[5]), 1);
        expect_frame(10, 0, 1);
        arm(10, 0, 1);
        drain();

        // R3/R4/R7: blocker held while others queue
        cfg(0, 15, 30'h0000_0100);
        cfg(1, 0, 30'h0000_0101);
        cfg(3, 7, 30'h0000_0103);
        cfg(9, 2, 30'h0000_0109);
        cfg(12, 2, 30'h0000_010C);
        expect_frame(0, 1, 0);
        expect_frame(1, 2, 0);
        expect_frame(9, 3, 0);
        expect_frame(12, 4, 0);
        expect_frame(3, 5, 0);
        accept_delay = 12;
        arm(0, 1, 0);
        arm(12, 4, 0);
        arm(3, 5, 0);
        arm(9, 3, 0);
        arm(1, 2, 0);
        drain();
        accept_delay = 0;
        check(served == 7, "R3 frames served", 64'(served), 7);

        // R5: requests to non-transmit mailboxes ignored
        wr(7, 3'd0, 32'h0);
        arm(7, 2, 0);
        wr(8, 3'd0, 32'd2 << 24);
        arm(8, 2, 0);
        repeat (4) @(negedge clk);
        check(mb_ready[7] == 1 && mb_ready[8] == 1, "R5 ready kept", 64'(mb_ready[8:7]), 3);
        check(frm_valid == 0, "R5 nothing offered", 64'(frm_valid), 0);

        // R6: identifier write ignored in transmit mode
        cfg(4, 1, 30'h0ABC_0004);
        wr(4, 3'd1, 32'h1111_1111);
        expect_frame(4, 6, 0);
        arm(4, 6, 0);
        drain();

        // R8: abort path, then re-request clears abort
        cfg(6, 4, 30'h0000_0606);
        abort_mode = 1;
        expect_frame(6, 7, 0);
        arm(6, 7, 0);
        drain();
        abort_mode = 0;
        check(mb_ready[6] == 1 && mb_abort[6] == 1, "R8 abort", {mb_ready[6], mb_abort[6]}, 2'b11);
        @(negedge clk); ev_clr = '1; @(negedge clk); ev_clr = '0;
        irq_en = 16'h0000;
        expect_frame(6, 7, 0);
        arm(6, 7, 0);
        check(mb_abort[6] == 0, "R8 request clears abort", 64'(mb_abort[6]), 0);
        drain();

        // R9: gating and clear
        check(irq == 0, "R9 irq masked", 64'(irq), 0);
        irq_en[6] = 1;
        @(negedge clk);
        check(irq == 16'h0040, "R9 irq enabled", 64'(irq), 64'h40);
        ev_clr[6] = 1; @(negedge clk); ev_clr[6] = 0; @(negedge clk);
        check(irq == 0, "R9 event cleared", 64'(irq), 0);

        // R10: stray completion pulses while idle
        irq_en = 16'hFFFF;
        @(negedge clk); ev_clr = '1; @(negedge clk); ev_clr = '0;
        wr(11, 3'd0, 32'h0);
        rsnap = mb_ready; isnap = irq;
        tx_done = 1; @(negedge clk); tx_done = 0;
        tx_abort = 1; @(negedge clk); tx_abort = 0;
        @(negedge clk);
        check(mb_ready == rsnap && mb_abort == 0, "R10 ready/abort", {mb_ready, mb_abort}, {rsnap, 16'h0});
        check(irq == isnap, "R10 irq", 64'(irq), 64'(isnap));

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule